// File: doc/BRIEF.md
# Edge-Driven Phase Step Controller

This block holds the phase offset of a clock phase aligner as a signed fraction of the output period. The fraction is kept as an unsigned index, modulo one full period. Two asynchronous control lines drive it: a step strobe and a direction line. On each rising edge of the step strobe, the block reads the direction line. A low level moves the output one step later. A high level moves it one step earlier. Downstream logic turns the resulting index into a tap select or an interpolator code.

The size of one step depends on the post-divider setting. The finest setting moves by one index unit, which is 1/3072 of a period. The next setting moves by two units, and the coarsest by four units (1/768 of a period). All settings share one accumulator. After every group of 32 strobe edges, a fixed pattern of edges is dropped, either one edge or two. The divider select and the two-skip selector are quasi-static inputs in the system clock domain. The two control lines each pass through a two-flop synchronizer.

Top module: `phase_step_ctrl`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, the phase index is 0. The group edge position is also 0, so the first edge after reset has position 0.
- R2: A rising edge on the step strobe changes the phase index on the third rising clock edge after the strobe input goes high. That is two synchronizer flops plus the phase register. A strobe that stays high, and a falling strobe, cause no change.
- R3: The direction line (lead/lag input) is sampled through its own two-flop synchronizer, in the same cycle the strobe edge is detected. Value 0 adds one step to the index (delay). Value 1 subtracts one step (advance).
- R4: The step weight in index units depends on the divider select: 2'b11 gives 4 units, 2'b10 gives 2 units, 2'b01 gives 1 unit. 2'b00 gives 0 units, but the edge still counts toward its group.
- R5: The index wraps modulo 3072 in both directions with no saturation. For example, advancing 4 units from 0 gives 3068.
- R6: Every detected strobe edge advances a group position counter that runs from 0 to 31 and then wraps. An edge whose position is 31 leaves the index unchanged.
- R7: When the two-skip selector is 1, an edge at position 15 also leaves the index unchanged. When the selector is 0, an edge at position 15 updates the index normally.
- R8: Holding the direction line at a constant level and applying N edges moves the index by (N minus skipped edges) times the step weight. At the coarsest setting, 192 delay edges from reset give 744 units, because 6 of those edges are skipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_strobe_i | input | 1 | Asynchronous step strobe; each rising edge is one step request |
| lead_lag_i | input | 1 | Asynchronous direction line: 0 = delay, 1 = advance |
| div_sel_i | input | 2 | Post-divider select that sets the step weight |
| two_skip_i | input | 1 | Selects the two-skip group pattern |
| phase_idx_o | output | 12 | Phase index, 0 to 3071, in units of 1/3072 of a period |

## Verification
The bench drives its inputs on falling clock edges. A strobe rise takes effect on the third following rising edge, so the latency test samples the index on the first and second falling edges after the rise and expects no change there. It then expects the new value on the third falling edge. Every other step request holds the direction line steady for three cycles before the strobe rises. It holds the strobe high for three cycles and low for two more, and only then compares the index with a reference model that applies the weights, skips and wrapping. This leaves a margin of at least one cycle past the due point. A separate test raises the direction line in the same cycle as the strobe, to confirm that both lines see equal synchronizer delay.

// File: rtl/psc_pkg.sv
package psc_pkg;

   typedef enum logic [1:0] {
      DIVSEL_OFF = 2'b00,
      DIVSEL_8   = 2'b01,
      DIVSEL_4   = 2'b10,
      DIVSEL_2   = 2'b11
   } divsel_e;

   typedef enum logic {
      DIR_LATER   = 1'b0,
      DIR_EARLIER = 1'b1
   } step_dir_e;

   typedef struct packed {
      logic      fire;
      step_dir_e dir;
   } step_req_t;

endpackage

// File: rtl/psc_sync.sv
module psc_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("psc_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("psc_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   generate
      for (genvar st = 0; st < STAGES; st++) begin : g_stage
         if (st == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[st] <= '0;
               else        chain_q[st] <= async_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[st] <= '0;
               else        chain_q[st] <= chain_q[st-1];
            end
         end
      end
   endgenerate

   assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/psc_edge_det.sv
module psc_edge_det
   import psc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      strobe_s,
   input  logic      dir_s,
   output step_req_t req_o
);

   logic strobe_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) strobe_prev_q <= 1'b0;
      else        strobe_prev_q <= strobe_s;
   end

   always_comb begin
      req_o.fire = strobe_s & ~strobe_prev_q;
      req_o.dir  = dir_s ? DIR_EARLIER : DIR_LATER;
   end

   // R2: one rising edge yields a one-cycle request, never two in a row
   a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      req_o.fire |=> !req_o.fire);

endmodule

// File: rtl/psc_skip_ctr.sv
module psc_skip_ctr #(
   parameter int GROUP_EDGES = 32,
   parameter int SKIP_MAIN   = 31,
   parameter int SKIP_EXTRA  = 15,
   parameter bit EXTRA_EN    = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire_i,
   input  logic two_skip_i,
   output logic apply_o
);

   localparam int POS_W = (GROUP_EDGES > 1) ? $clog2(GROUP_EDGES) : 1;
   localparam logic [POS_W-1:0] POS_LAST  = POS_W'(GROUP_EDGES - 1);
   localparam logic [POS_W-1:0] POS_MAIN  = POS_W'(SKIP_MAIN);
   localparam logic [POS_W-1:0] POS_EXTRA = POS_W'(SKIP_EXTRA);

   generate
      if (GROUP_EDGES < 2) begin : g_bad_group
         $error("psc_skip_ctr: GROUP_EDGES must be at least 2");
      end
      if (SKIP_MAIN >= GROUP_EDGES || SKIP_EXTRA >= GROUP_EDGES) begin : g_bad_skip
         $error("psc_skip_ctr: skip positions must lie inside the group");
      end
      if (SKIP_MAIN == SKIP_EXTRA) begin : g_same_skip
         $error("psc_skip_ctr: skip positions must differ");
      end
   endgenerate

   logic [POS_W-1:0] pos_q;
   logic             skip_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= '0;
      end else if (fire_i) begin
         pos_q <= (pos_q == POS_LAST) ? '0 : pos_q + 1'b1;
      end
   end

   generate
      if (EXTRA_EN) begin : g_two_pattern
         assign skip_hit = (pos_q == POS_MAIN) || (two_skip_i && (pos_q == POS_EXTRA));
      end else begin : g_one_pattern
         logic unused_two;
         assign unused_two = two_skip_i;
         assign skip_hit   = (pos_q == POS_MAIN);
      end
   endgenerate

   assign apply_o = fire_i & ~skip_hit;

   // R6: the position wraps to zero after the last edge of a group
   a_r6_group_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (fire_i && pos_q == POS_LAST) |=> (pos_q == '0));

   // R6: the position moves only on a detected edge
   a_r6_pos_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !fire_i |=> $stable(pos_q));

   // R6: the main skip position never yields an update
   a_r6_main_skip: assert property (@(posedge clk) disable iff (!rst_n)
      (pos_q == POS_MAIN) |-> !apply_o);

endmodule

// File: rtl/psc_phase_acc.sv
module psc_phase_acc
   import psc_pkg::*;
#(
   parameter int FULL_UNITS = 3072,
   parameter int W_DIV2     = 4,
   parameter int W_DIV4     = 2,
   parameter int W_DIV8     = 1,
   localparam int PHASE_W   = $clog2(FULL_UNITS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               apply_i,
   input  step_dir_e          dir_i,
   input  logic [1:0]         div_sel_i,
   output logic [PHASE_W-1:0] phase_o
);

   localparam int SUM_W = PHASE_W + 1;
   localparam logic [SUM_W-1:0] FULL_L = SUM_W'(FULL_UNITS);
   localparam bit POW2 = ((FULL_UNITS & (FULL_UNITS - 1)) == 0);

   generate
      if (FULL_UNITS < 2) begin : g_bad_full
         $error("psc_phase_acc: FULL_UNITS must be at least 2");
      end
      if (W_DIV2 >= FULL_UNITS || W_DIV4 >= FULL_UNITS || W_DIV8 >= FULL_UNITS) begin : g_bad_weight
         $error("psc_phase_acc: step weights must be below one period");
      end
   endgenerate

   logic [PHASE_W-1:0] phase_q;
   logic [SUM_W-1:0]   step_units;
   logic [PHASE_W-1:0] phase_later;
   logic [PHASE_W-1:0] phase_earlier;

   always_comb begin
      unique case (divsel_e'(div_sel_i))
         DIVSEL_2:   step_units = SUM_W'(W_DIV2);
         DIVSEL_4:   step_units = SUM_W'(W_DIV4);
         DIVSEL_8:   step_units = SUM_W'(W_DIV8);
         default:    step_units = '0;
      endcase
   end

   generate
      if (POW2) begin : g_natural_wrap
         logic [SUM_W-1:0] up_n, dn_n;
         assign up_n          = {1'b0, phase_q} + step_units;
         assign dn_n          = {1'b0, phase_q} - step_units;
         assign phase_later   = up_n[PHASE_W-1:0];
         assign phase_earlier = dn_n[PHASE_W-1:0];
      end else begin : g_compare_wrap
         logic [SUM_W-1:0] up_sum, dn_diff, up_fix, dn_fix;
         assign up_sum        = {1'b0, phase_q} + step_units;
         assign up_fix        = (up_sum >= FULL_L) ? (up_sum - FULL_L) : up_sum;
         assign dn_diff       = {1'b0, phase_q} + FULL_L - step_units;
         assign dn_fix        = (dn_diff >= FULL_L) ? (dn_diff - FULL_L) : dn_diff;
         assign phase_later   = up_fix[PHASE_W-1:0];
         assign phase_earlier = dn_fix[PHASE_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
      end else if (apply_i) begin
         phase_q <= (dir_i == DIR_EARLIER) ? phase_earlier : phase_later;
      end
   end

   assign phase_o = phase_q;

   // R5: the index never leaves one period
   a_r5_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, phase_q} < FULL_L));

   // R6: without an applied update the index holds
   a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !apply_i |=> $stable(phase_q));

   // R4: the zero-weight setting never moves the index
   a_r4_off_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (div_sel_i == 2'b00) |=> $stable(phase_q));

   // R3: an applied non-zero step always changes the index
   a_r3_step_moves: assert property (@(posedge clk) disable iff (!rst_n)
      (apply_i && step_units != '0) |=> !$stable(phase_q));

endmodule

// File: rtl/phase_step_ctrl.sv
module phase_step_ctrl
   import psc_pkg::*;
#(
   parameter int FULL_UNITS  = 3072,
   parameter int W_DIV2      = 4,
   parameter int W_DIV4      = 2,
   parameter int W_DIV8      = 1,
   parameter int SYNC_STAGES = 2,
   parameter int GROUP_EDGES = 32,
   parameter int SKIP_MAIN   = 31,
   parameter int SKIP_EXTRA  = 15,
   parameter bit EXTRA_EN    = 1'b1,
   localparam int PHASE_W    = $clog2(FULL_UNITS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               step_strobe_i,
   input  logic               lead_lag_i,
   input  logic [1:0]         div_sel_i,
   input  logic               two_skip_i,
   output logic [PHASE_W-1:0] phase_idx_o
);

   logic [1:0] ctl_sync;
   step_req_t  req;
   logic       apply;

   psc_sync #(
      .WIDTH  (2),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i ({lead_lag_i, step_strobe_i}),
      .sync_o  (ctl_sync)
   );

   psc_edge_det u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe_s (ctl_sync[0]),
      .dir_s    (ctl_sync[1]),
      .req_o    (req)
   );

   psc_skip_ctr #(
      .GROUP_EDGES (GROUP_EDGES),
      .SKIP_MAIN   (SKIP_MAIN),
      .SKIP_EXTRA  (SKIP_EXTRA),
      .EXTRA_EN    (EXTRA_EN)
   ) u_skip (
      .clk        (clk),
      .rst_n      (rst_n),
      .fire_i     (req.fire),
      .two_skip_i (two_skip_i),
      .apply_o    (apply)
   );

   psc_phase_acc #(
      .FULL_UNITS (FULL_UNITS),
      .W_DIV2     (W_DIV2),
      .W_DIV4     (W_DIV4),
      .W_DIV8     (W_DIV8)
   ) u_acc (
      .clk       (clk),
      .rst_n     (rst_n),
      .apply_i   (apply),
      .dir_i     (req.dir),
      .div_sel_i (div_sel_i),
      .phase_o   (phase_idx_o)
   );

   // R6: an update is only ever applied for a detected edge
   a_r6_apply_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
      apply |-> req.fire);

   // R2: a steady synchronized strobe produces no request
   a_r2_level_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(ctl_sync[0]) |-> !req.fire);

endmodule

// File: tb/phase_step_ctrl_bench.sv
module phase_step_ctrl_bench;

   localparam int FULL = 3072;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        strobe = 1'b0;
   logic        lead = 1'b0;
   logic [1:0]  sel = 2'b11;
   logic        two = 1'b0;
   logic [11:0] phase;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   int m_phase;
   int m_pos;

   always #2 clk = ~clk;   // 250 MHz

   phase_step_ctrl u_phase_step_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .step_strobe_i (strobe),
      .lead_lag_i    (lead),
      .div_sel_i     (sel),
      .two_skip_i    (two),
      .phase_idx_o   (phase)
   );

   function automatic int weight(logic [1:0] s);
      case (s)
         2'b11:   return 4;
         2'b10:   return 2;
         2'b01:   return 1;
         default: return 0;
      endcase
   endfunction

   task automatic check(string tag, int exp);
      n_chk++;
      if (int'(phase) != exp) begin
         n_bad++;
         $display("FAIL %s: phase actual %0d expected %0d", tag, phase, exp);
      end
   endtask

   function automatic void model_edge(bit adv);
      bit skipped = (m_pos == 31) || (two && m_pos == 15);
      if (!skipped) begin
         if (adv) m_phase = (m_phase - weight(sel) + FULL) % FULL;
         else     m_phase = (m_phase + weight(sel)) % FULL;
      end
      m_pos = (m_pos + 1) % 32;
   endfunction

   task automatic do_reset();
      @(negedge clk);
      strobe = 1'b0;
      lead   = 1'b0;
      rst_n  = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 in reset", 0);
      rst_n = 1'b1;
      @(negedge clk);
      m_phase = 0;
      m_pos   = 0;
      check("R1 after release", 0);
   endtask

   task automatic step(bit adv, string tag);
      @(negedge clk);
      lead = adv;
      repeat (3) @(negedge clk);
      strobe = 1'b1;
      repeat (3) @(negedge clk);
      strobe = 1'b0;
      repeat (2) @(negedge clk);
      model_edge(adv);
      check(tag, m_phase);
   endtask

   task automatic t_latency();
      do_reset();
      sel = 2'b11;
      @(negedge clk);
      strobe = 1'b1;
      @(negedge clk);
      check("R2 one cycle after rise", 0);
      @(negedge clk);
      check("R2 two cycles after rise", 0);
      @(negedge clk);
      check("R2 three cycles after rise", 4);
      repeat (10) @(negedge clk);
      check("R2 held high", 4);
      strobe = 1'b0;
      repeat (10) @(negedge clk);
      check("R2 falling edge", 4);
      m_phase = 4;
      m_pos   = 1;
   endtask

   task automatic t_directions();
      do_reset();
      sel = 2'b11;
      step(1'b0, "R3 delay");
      step(1'b0, "R3 delay again");
      step(1'b1, "R3 advance");
      // direction and strobe rise together; equal sync delay
      @(negedge clk);
      lead   = 1'b1;
      strobe = 1'b1;
      repeat (3) @(negedge clk);
      strobe = 1'b0;
      repeat (2) @(negedge clk);
      model_edge(1'b1);
      check("R3 simultaneous direction", m_phase);
   endtask

   task automatic t_weights();
      do_reset();
      sel = 2'b10;
      step(1'b0, "R4 weight two");
      sel = 2'b01;
      step(1'b0, "R4 weight one");
      sel = 2'b00;
      step(1'b0, "R4 weight zero");
      sel = 2'b11;
      step(1'b0, "R4 weight four");
      check("R4 total", 7);
   endtask

   task automatic t_wrap();
      do_reset();
      sel = 2'b11;
      step(1'b1, "R5 advance below zero");
      check("R5 wrap value", 3068);
      step(1'b0, "R5 delay across top");
      check("R5 back to zero", 0);
      sel = 2'b01;
      step(1'b1, "R5 fine wrap");
      check("R5 fine wrap value", 3071);
   endtask

   task automatic t_skip_one();
      do_reset();
      sel = 2'b01;
      two = 1'b0;
      for (int i = 0; i < 33; i++) step(1'b0, "R6 group edge");
      check("R6 one skip in 33 edges", 32);
      check("R7 position 15 applied when off", 32);
   endtask

   task automatic t_skip_two();
      do_reset();
      sel = 2'b01;
      two = 1'b1;
      for (int i = 0; i < 32; i++) step(1'b0, "R7 group edge");
      check("R7 two skips in 32 edges", 30);
      two = 1'b0;
   endtask

   task automatic t_zero_counts();
      do_reset();
      sel = 2'b00;
      for (int i = 0; i < 31; i++) step(1'b0, "R4 zero weight edge");
      sel = 2'b01;
      step(1'b0, "R6 position 31 after zero-weight edges");
      check("R6 skip reached by zero-weight edges", 0);
      step(1'b0, "R6 new group");
      check("R6 new group value", 1);
   endtask

   task automatic t_quarter();
      do_reset();
      sel = 2'b11;
      for (int i = 0; i < 192; i++) step(1'b0, "R8 fixed delay");
      check("R8 192 edges", 744);
      do_reset();
      for (int i = 0; i < 40; i++) step(1'b1, "R8 fixed advance");
      check("R8 40 advances", (FULL - 39 * 4) % FULL);
   endtask

   initial begin
      t_latency();
      t_directions();
      t_weights();
      t_wrap();
      t_skip_one();
      t_skip_two();
      t_zero_counts();
      t_quarter();
      do_reset();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule